// File: doc/BRIEF.md
# Paged Boot-Swap Chip-Select Decoder

This block turns the 16-bit address of a small microcontroller into chip selects for a larger set of on-chip memories. There are eight flash segments, four EEPROM segments, one SRAM, one control-register block and one external device. The lower half of the address space, 0000-7FFF, is a window that shows one of four pages. The upper half, 8000-FFFF, is common to every page.

An 8-bit page register, written by the processor, holds three controls:

- A two-bit page number.
- A swap bit. When swap is clear, the boot EEPROM sits under the reset vector. When swap is set, a flash segment takes that region and the boot EEPROM moves into the page-3 window.
- An unlock bit. The moved boot EEPROM is reachable only while unlock is set.

Where regions overlap, a fixed priority decides the winner: SRAM and I/O first, then EEPROM, then flash.

The page register resets to zero, so the first fetch after reset comes from EEPROM. Every select is registered. A select reflects the address presented one clock earlier and the page register value in effect during that same clock.

Top module: `pbs_decoder`

## Requirements
- R1: Synchronous active-high reset clears the page register to 00h and drives every select inactive. After reset, address FFFE selects EEPROM segment 1 (`ee_sel[1]`).
- R2: A clock with `wr_en` high and `bus_addr` equal to 8AF0h loads `wr_data` into the page register, and `page_q` shows the new value from the next cycle on. A `wr_en` at any other address leaves `page_q` unchanged. Page register fields: bits 1:0 are the page number, bit 6 is unlock, bit 7 is swap.
- R3: With swap = 0, C000-DFFF selects `ee_sel[0]` and E000-FFFF selects `ee_sel[1]` on every page. On page 3, 4000-7FFF selects `fs_sel[7]`.
- R4: With swap = 1, C000-FFFF selects `fs_sel[7]` on every page.
- R5: With swap = 1 on page 3, 4000-5FFF selects `ee_sel[0]` and 6000-7FFF selects `ee_sel[1]` only when unlock = 1. With unlock = 0, that range asserts no select.
- R6: On page 3, 0000-1FFF selects `ee_sel[2]` and 2000-3FFF selects `ee_sel[3]`, whatever the values of swap and unlock.
- R7: 9000-BFFF selects `fs_sel[0]` on every page. For page n in 0..2, 0000-3FFF selects `fs_sel[2n+1]` and 4000-7FFF selects `fs_sel[2n+2]`.
- R8: On every page, 8200-89FF selects `sram_sel`, 8A00-8AFF selects `ctrl_sel`, and 8C00-8FFF drives `ext_sel_n` low.
- R9: At most one select is active at a time, with priority SRAM/I/O over EEPROM over flash. The address ranges 8000-81FF and 8B00-8BFF assert no select.
- R10: Selects are registered with a latency of one clock. A change of address or page register shows at the outputs one clock after it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Processor address |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Processor write data |
| page_q | output | 8 | Page register readback |
| fs_sel | output | 8 | Flash segment selects, active high |
| ee_sel | output | 4 | EEPROM segment selects, active high |
| sram_sel | output | 1 | SRAM select, active high |
| ctrl_sel | output | 1 | Control-register block select, active high |
| ext_sel_n | output | 1 | External device select, active low |

## Verification
A page register that holds the wrong value shows up as a wrong select on the next access to the paged window or to the swappable regions, one clock after that address is presented. A wrong swap or unlock bit misplaces the boot area at C000-FFFF or in the page-3 window. The same applies to a write decoded at the wrong offset, or to reset failing to clear the register.

The bench compares all fifteen select outputs on every cycle against a model built from the address map. It runs random addresses and random page register writes, mixed with directed points at the region edges. Because every cycle is compared, a priority or overlap fault appears at the first address that hits the faulty region.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  localparam int ADDR_W = 16;
  localparam int PAGE_W = 2;
  localparam int NUM_FS = 8;
  localparam int NUM_EE = 4;
  localparam int NUM_FS_PAGES = 3;

  localparam logic [ADDR_W-1:0] WIN_LO_BASE  = 16'h0000;
  localparam logic [ADDR_W-1:0] WIN_HI_BASE  = 16'h4000;
  localparam logic [ADDR_W-1:0] WIN_SIZE     = 16'h4000;
  localparam logic [ADDR_W-1:0] HALF_WIN     = 16'h2000;
  localparam logic [ADDR_W-1:0] SRAM_LO      = 16'h8200;
  localparam logic [ADDR_W-1:0] SRAM_HI      = 16'h89FF;
  localparam logic [ADDR_W-1:0] CTRL_LO      = 16'h8A00;
  localparam logic [ADDR_W-1:0] CTRL_HI      = 16'h8AFF;
  localparam logic [ADDR_W-1:0] EXT_LO       = 16'h8C00;
  localparam logic [ADDR_W-1:0] EXT_HI       = 16'h8FFF;
  localparam logic [ADDR_W-1:0] FS0_LO       = 16'h9000;
  localparam logic [ADDR_W-1:0] FS0_HI       = 16'hBFFF;
  localparam logic [ADDR_W-1:0] BOOT_LO      = 16'hC000;
  localparam logic [ADDR_W-1:0] BOOT_MID     = 16'hE000;
  localparam logic [ADDR_W-1:0] TOP_ADDR     = 16'hFFFF;

  localparam logic [PAGE_W-1:0] SHARED_PAGE  = 2'd3;

  // Raw or resolved select set, all active high internally
  typedef struct packed {
    logic [NUM_FS-1:0] fs;
    logic [NUM_EE-1:0] ee;
    logic              sram;
    logic              ctrl;
    logic              ext;
  } sel_t;

  function automatic logic in_rng(input logic [ADDR_W-1:0] a,
                                  input logic [ADDR_W-1:0] lo,
                                  input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

endpackage

// File: rtl/pbs_page_reg.sv
module pbs_page_reg #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR = 16'h8AF0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] page_q
);

  logic hit;
  assign hit = wr_en && (bus_addr == WR_ADDR);

  always_ff @(posedge clk) begin
    if (rst)      page_q <= '0;
    else if (hit) page_q <= wr_data;
  end

endmodule

// File: rtl/pbs_region_match.sv
module pbs_region_match
  import pbs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] page,
  input  logic              swap,
  input  logic              unlock,
  output sel_t              raw
);

  logic [NUM_FS-1:0] fs_w;
  logic [NUM_EE-1:0] ee_w;
  logic in_lo_win, in_hi_win, on_shared;

  assign in_lo_win = in_rng(addr, WIN_LO_BASE, WIN_LO_BASE + WIN_SIZE - 16'd1);
  assign in_hi_win = in_rng(addr, WIN_HI_BASE, WIN_HI_BASE + WIN_SIZE - 16'd1);
  assign on_shared = (page == SHARED_PAGE);

  // Common flash segment
  assign fs_w[0] = in_rng(addr, FS0_LO, FS0_HI);

  // Paged flash pairs on pages 0..NUM_FS_PAGES-1
  for (genvar k = 0; k < NUM_FS_PAGES; k++) begin : g_fs_page
    localparam logic [PAGE_W-1:0] PG = PAGE_W'(k);
    assign fs_w[2*k+1] = in_lo_win && (page == PG);
    assign fs_w[2*k+2] = in_hi_win && (page == PG);
  end

  // Swappable flash segment
  assign fs_w[7] = (in_hi_win && on_shared && !swap) ||
                   (in_rng(addr, BOOT_LO, TOP_ADDR) && swap);

  // Boot EEPROM, either at the vector region or in the shared page window
  assign ee_w[0] = (in_rng(addr, BOOT_LO, BOOT_MID - 16'd1) && !swap) ||
                   (in_rng(addr, WIN_HI_BASE, WIN_HI_BASE + HALF_WIN - 16'd1)
                    && on_shared && swap && unlock);
  assign ee_w[1] = (in_rng(addr, BOOT_MID, TOP_ADDR) && !swap) ||
                   (in_rng(addr, WIN_HI_BASE + HALF_WIN, WIN_HI_BASE + WIN_SIZE - 16'd1)
                    && on_shared && swap && unlock);

  // Data EEPROM in the shared page low window
  assign ee_w[2] = in_rng(addr, WIN_LO_BASE, WIN_LO_BASE + HALF_WIN - 16'd1) && on_shared;
  assign ee_w[3] = in_rng(addr, WIN_LO_BASE + HALF_WIN, WIN_LO_BASE + WIN_SIZE - 16'd1)
                   && on_shared;

  always_comb begin
    raw.fs   = fs_w;
    raw.ee   = ee_w;
    raw.sram = in_rng(addr, SRAM_LO, SRAM_HI);
    raw.ctrl = in_rng(addr, CTRL_LO, CTRL_HI);
    raw.ext  = in_rng(addr, EXT_LO, EXT_HI);
  end

endmodule

// File: rtl/pbs_priority_sel.sv
module pbs_priority_sel
  import pbs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  sel_t raw,
  output sel_t sel_q
);

  sel_t res;
  logic lvl1_hit, lvl2_hit;

  assign lvl1_hit = raw.sram || raw.ctrl || raw.ext;
  assign lvl2_hit = |raw.ee;

  // Level 1 (SRAM/I/O) over level 2 (EEPROM) over level 3 (flash);
  // inside each level the lowest index wins.
  always_comb begin
    res = '0;
    if (lvl1_hit) begin
      if (raw.ctrl)      res.ctrl = 1'b1;
      else if (raw.sram) res.sram = 1'b1;
      else               res.ext  = 1'b1;
    end else if (lvl2_hit) begin
      for (int i = NUM_EE-1; i >= 0; i--)
        if (raw.ee[i]) begin
          res.ee    = '0;
          res.ee[i] = 1'b1;
        end
    end else begin
      for (int i = NUM_FS-1; i >= 0; i--)
        if (raw.fs[i]) begin
          res.fs    = '0;
          res.fs[i] = 1'b1;
        end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else     sel_q <= res;
  end

endmodule

// File: rtl/pbs_decoder.sv
module pbs_decoder
  import pbs_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SWAP_BIT = 7,
  parameter int UNLK_BIT = 6,
  parameter logic [7:0] PREG_OFS = 8'hF0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   page_q,
  output logic [NUM_FS-1:0]   fs_sel,
  output logic [NUM_EE-1:0]   ee_sel,
  output logic                sram_sel,
  output logic                ctrl_sel,
  output logic                ext_sel_n
);

  localparam logic [ADDR_W-1:0] WR_ADDR = CTRL_LO + {8'h00, PREG_OFS};

  sel_t raw, sel_q;

  pbs_page_reg #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .WR_ADDR(WR_ADDR)
  ) u_preg (
    .clk     (clk),
    .rst     (rst),
    .bus_addr(bus_addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .page_q  (page_q)
  );

  pbs_region_match u_match (
    .addr  (bus_addr),
    .page  (page_q[PAGE_W-1:0]),
    .swap  (page_q[SWAP_BIT]),
    .unlock(page_q[UNLK_BIT]),
    .raw   (raw)
  );

  pbs_priority_sel u_prio (
    .clk  (clk),
    .rst  (rst),
    .raw  (raw),
    .sel_q(sel_q)
  );

  assign fs_sel    = sel_q.fs;
  assign ee_sel    = sel_q.ee;
  assign sram_sel  = sel_q.sram;
  assign ctrl_sel  = sel_q.ctrl;
  assign ext_sel_n = ~sel_q.ext;

endmodule

// File: rtl/pbs_decoder_chk.sv
module pbs_decoder_chk #(
  parameter logic [15:0] WR_ADDR = 16'h8AF0
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_addr,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  page_q,
  input logic [7:0]  fs_sel,
  input logic [3:0]  ee_sel,
  input logic        sram_sel,
  input logic        ctrl_sel,
  input logic        ext_sel_n
);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (page_q == 8'h00 && fs_sel == 8'h00 && ee_sel == 4'h0));

  assert_preg_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && bus_addr == WR_ADDR) |=> (page_q == $past(wr_data)));

  assert_preg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && bus_addr == WR_ADDR) |=> $stable(page_q));

  assert_boot_ee_R3: assert property (@(posedge clk) disable iff (rst)
    (!page_q[7] && bus_addr[15:13] == 3'b111) |=> ee_sel[1]);

  assert_swap_flash_R4: assert property (@(posedge clk) disable iff (rst)
    (page_q[7] && bus_addr[15:14] == 2'b11) |=> fs_sel[7]);

  assert_locked_R5: assert property (@(posedge clk) disable iff (rst)
    (page_q[7] && !page_q[6] && page_q[1:0] == 2'd3 && bus_addr[15:14] == 2'b01)
    |=> (fs_sel == 8'h00 && ee_sel == 4'h0));

  assert_one_sel_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fs_sel, ee_sel, sram_sel, ctrl_sel, ~ext_sel_n}));

endmodule

bind pbs_decoder pbs_decoder_chk #(.WR_ADDR(WR_ADDR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_addr (bus_addr),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .page_q   (page_q),
  .fs_sel   (fs_sel),
  .ee_sel   (ee_sel),
  .sram_sel (sram_sel),
  .ctrl_sel (ctrl_sel),
  .ext_sel_n(ext_sel_n)
);

// File: tb/pbs_decoder_bench.sv
module pbs_decoder_bench;

  localparam logic [15:0] PREG_ADDR = 16'h8AF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  page_q;
  logic [7:0]  fs_sel;
  logic [3:0]  ee_sel;
  logic        sram_sel, ctrl_sel, ext_sel_n;

  int checks = 0;
  int errors = 0;
  logic [7:0] model_pg = 8'h00;
  bit done = 0;

  always #5 clk = ~clk;

  pbs_decoder u_pbs_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
    .page_q(page_q), .fs_sel(fs_sel), .ee_sel(ee_sel), .sram_sel(sram_sel),
    .ctrl_sel(ctrl_sel), .ext_sel_n(ext_sel_n)
  );

  // Expected {fs[7:0], ee[3:0], sram, ctrl, ext_n}
  function automatic logic [14:0] expect_sel(input logic [15:0] a, input logic [7:0] pg);
    logic [7:0] fs;
    logic [3:0] ee;
    logic sr, ct, ex;
    logic [1:0] p;
    logic sw, ul;
    p = pg[1:0]; sw = pg[7]; ul = pg[6];
    fs = '0; ee = '0; sr = 0; ct = 0; ex = 0;
    if (a >= 16'h8200 && a <= 16'h89FF)      sr = 1;
    else if (a >= 16'h8A00 && a <= 16'h8AFF) ct = 1;
    else if (a >= 16'h8C00 && a <= 16'h8FFF) ex = 1;
    else if (a >= 16'h9000 && a <= 16'hBFFF) fs[0] = 1;
    else if (a >= 16'hC000) begin
      if (sw) fs[7] = 1;
      else if (a < 16'hE000) ee[0] = 1;
      else ee[1] = 1;
    end else if (a < 16'h8000) begin
      if (p != 2'd3) fs[{p, 1'b0} + {2'b00, a[14]} + 3'd1] = 1;
      else if (a < 16'h2000) ee[2] = 1;
      else if (a < 16'h4000) ee[3] = 1;
      else if (!sw) fs[7] = 1;
      else if (ul) begin
        if (a < 16'h6000) ee[0] = 1; else ee[1] = 1;
      end
    end
    return {fs, ee, sr, ct, ~ex};
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One bus cycle: drive at negedge, sample at the following negedge
  task automatic cycle(input logic [15:0] a, input logic we, input logic [7:0] d,
                       input string req);
    logic [14:0] exp;
    bus_addr = a; wr_en = we; wr_data = d;
    exp = expect_sel(a, model_pg);
    if (we && a == PREG_ADDR) model_pg = d;
    @(posedge clk);
    @(negedge clk);
    check(req, {fs_sel, ee_sel, sram_sel, ctrl_sel, ext_sel_n}, exp);
    checks++;
    if (page_q !== model_pg) begin
      errors++;
      $display("FAIL R2: page_q actual %h expected %h", page_q, model_pg);
    end
    wr_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check("R1 reset selects", {fs_sel, ee_sel, sram_sel, ctrl_sel, ext_sel_n}, 15'h0001);
    check("R1 page_q", {7'h0, page_q}, 15'h0000);
    rst = 0;
    cycle(16'hFFFE, 0, 0, "R1 boot vector ee1");
    cycle(16'hC000, 0, 0, "R3 ee0");
    cycle(16'h8300, 0, 0, "R8 sram");
    cycle(16'h8A00, 0, 0, "R8 ctrl");
    cycle(16'h8FFF, 0, 0, "R8 ext");
    cycle(16'h8000, 0, 0, "R9 hole low");
    cycle(16'h8B00, 0, 0, "R9 hole mid");
    cycle(16'h9000, 0, 0, "R7 fs0");
    cycle(16'h1234, 1, 8'h03, "R2 ignored write");
    cycle(16'h1234, 0, 0, "R2 page still 0 -> fs1");
    cycle(PREG_ADDR, 1, 8'h02, "R2 write page 2");
    cycle(16'h2000, 0, 0, "R7 page2 fs5");
    cycle(PREG_ADDR, 1, 8'h03, "R2 write page 3");
    cycle(16'h5000, 0, 0, "R3 page3 fs7");
    cycle(16'h0000, 0, 0, "R6 ee2");
    cycle(16'h3FFF, 0, 0, "R6 ee3");
    cycle(PREG_ADDR, 1, 8'h83, "R2 swap on");
    cycle(16'hFFFE, 0, 0, "R4 swap fs7");
    cycle(16'h4000, 0, 0, "R5 locked");
    cycle(16'h1FFF, 0, 0, "R6 ee2 swapped");
    cycle(PREG_ADDR, 1, 8'hC3, "R2 unlock");
    cycle(16'h5FFF, 0, 0, "R5 ee0 moved");
    cycle(16'h6000, 0, 0, "R5 ee1 moved");
    cycle(16'h8A55, 0, 0, "R10 latency");
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a;
      logic we;
      logic [7:0] d;
      a = 16'($urandom);
      we = ($urandom % 8) == 0;
      d = 8'($urandom);
      if (we && ($urandom % 2)) a = PREG_ADDR;
      cycle(a, we, d, "R9 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule